// File: doc/BRIEF.md
# Processor Operating State Controller

This block sequences the operating mode of a simple processor core. It has four modes: held in reset, running instructions, servicing an exception, and idling until an interrupt. The core's decode logic supplies strobes that say an exception was recognized or a WAIT instruction was decoded. An interrupt line wakes the idle core. A 3-bit status code on the system interface always shows the current mode.

When an exception is taken, the block saves the core's context onto a downward-growing stack and then loads the handler's context. It does this through a single request/ready memory port, one transfer at a time. It first writes the combined status/module word and then the program counter. After that it reads a linkage word and the new program counter from a vector location. Running resumes only after the last of these transfers has completed. At that point the new program counter and linkage word are presented with a one-cycle load pulse.

The datapath, instruction decode, the memory and any arbitration among exception sources lie outside the block.

Top module: `opStateTop`

## Requirements
- R1: `statusCode` shows the state register with the encoding 000 reset, 001 running, 010 exception service, 011 waiting. It changes on the clock edge at which the state changes.
- R2: A clock edge with `rst` high puts the block in reset from any state, and it stays there while `rst` stays high. In reset, `sp` equals `SP_RESET`, `pcOut` equals `RESET_PC`, `linkOut` is zero and `pcLoaded` is low.
- R3: The first clock edge in reset with `rst` low moves the block to running.
- R4: While running, `excReq` moves the block to exception service. Otherwise `waitReq` moves it to waiting. When both are high in the same cycle, exception service wins. `intReq` has no effect while running.
- R5: While waiting, `intReq` moves the block to exception service. `excReq` and `waitReq` have no effect.
- R6: Exception service issues four transfers in this order:
  - a write of `{psrIn, modIn}` (PSR in the upper bits) to `sp-1`;
  - a write of `pcIn` to the original `sp-2`;
  - a read of the linkage word from `vecAddr`;
  - a read of the new program counter from `vecAddr+1`.
  `pcIn`, `psrIn`, `modIn` and `vecAddr` are sampled on the edge that enters exception service. `memWe` is 1 for writes and 0 for reads.
- R7: Each transfer holds `memReq` high, with `memAddr`, `memWe` and `memWdata` stable, until a clock edge with `memReady` high. The next transfer is requested in the following cycle with no idle cycle between. `sp` drops by one at each completed write.
- R8: On the edge that completes the fourth transfer, the block returns to running. At that edge `pcOut` takes the read data of the fourth transfer and `linkOut` holds the read data of the third. `pcLoaded` is high for exactly that first running cycle.
- R9: `memReq` is low in every state other than exception service, and low in any cycle with `rst` high. A reset therefore abandons a transfer in progress.
- R10: `excReq`, `waitReq` and `intReq` have no effect during exception service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| excReq | input | 1 | Exception recognized strobe |
| waitReq | input | 1 | WAIT instruction decoded strobe |
| intReq | input | 1 | Interrupt request |
| pcIn | input | DW | Current program counter of the core |
| psrIn | input | PSR_W | Current processor status word |
| modIn | input | MOD_W | Current module register |
| vecAddr | input | DW | Address of the handler's linkage word |
| memReq | output | 1 | Transfer request |
| memWe | output | 1 | 1 for a write, 0 for a read |
| memAddr | output | DW | Transfer word address |
| memWdata | output | DW | Write data |
| memReady | input | 1 | Transfer completes on an edge with this high |
| memRdata | input | DW | Read data, valid with memReady |
| statusCode | output | 3 | Current operating state |
| sp | output | DW | Stack pointer |
| pcOut | output | DW | Program counter to resume from |
| linkOut | output | DW | Module linkage word of the handler |
| pcLoaded | output | 1 | One-cycle pulse when new context is loaded |

## Verification
Two pairs of events can coincide in one cycle. The first pair is an exception strobe and a WAIT strobe arriving together while running. The second is a reset edge landing in the middle of an outstanding stack transfer. The bench raises both strobes in one cycle and expects exception service with the first push on the next cycle. It also asserts reset while a slow memory holds a request open, and expects `memReq` to drop in that same cycle and the reset values to return.

// File: rtl/opStatePkg.sv
package opStatePkg;

  typedef enum logic [2:0] {
    ST_RESET = 3'b000,
    ST_EXEC  = 3'b001,
    ST_EXC   = 3'b010,
    ST_WAIT  = 3'b011
  } opState_e;

  // Order of the exception entry transfers; the sequence is behaviour.
  typedef enum logic [1:0] {
    XF_PUSH_CTX  = 2'd0,
    XF_PUSH_PC   = 2'd1,
    XF_READ_LINK = 2'd2,
    XF_READ_PC   = 2'd3
  } xferStep_e;

  typedef struct packed {
    logic      initRegs;
    logic      latchCtx;
    logic      spDec;
    logic      linkLoad;
    logic      pcLoad;
    xferStep_e step;
  } ctrlStrobe_t;

endpackage

// File: rtl/opStateCtrl.sv
module opStateCtrl
  import opStatePkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        excReq,
  input  logic        waitReq,
  input  logic        intReq,
  input  logic        memReady,
  output opState_e    stateQ,
  output logic        memReq,
  output ctrlStrobe_t strobes
);

  opState_e  stateD;
  xferStep_e stepQ, stepD;
  logic      inExc, xferDone, lastXfer, enterExc, pushStep;

  assign inExc    = (stateQ == ST_EXC);
  assign xferDone = inExc && memReady;
  assign lastXfer = (stepQ == XF_READ_PC);
  assign pushStep = (stepQ == XF_PUSH_CTX) || (stepQ == XF_PUSH_PC);
  assign enterExc = ((stateQ == ST_EXEC) && excReq) ||
                    ((stateQ == ST_WAIT) && intReq);

  always_comb begin
    stateD = stateQ;
    stepD  = stepQ;
    unique case (stateQ)
      ST_RESET: stateD = ST_EXEC;
      ST_EXEC: begin
        if (excReq) begin
          stateD = ST_EXC;
          stepD  = XF_PUSH_CTX;
        end else if (waitReq) begin
          stateD = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (intReq) begin
          stateD = ST_EXC;
          stepD  = XF_PUSH_CTX;
        end
      end
      ST_EXC: begin
        if (memReady) begin
          if (lastXfer) stateD = ST_EXEC;
          stepD = xferStep_e'(stepQ + 2'd1);
        end
      end
      default: stateD = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_RESET;
      stepQ  <= XF_PUSH_CTX;
    end else begin
      stateQ <= stateD;
      stepQ  <= stepD;
    end
  end

  // Reset gates the request in the same cycle so a pending transfer is dropped.
  assign memReq = inExc && !rst;

  always_comb begin
    strobes.initRegs = rst;
    strobes.latchCtx = !rst && enterExc;
    strobes.spDec    = !rst && xferDone && pushStep;
    strobes.linkLoad = !rst && xferDone && (stepQ == XF_READ_LINK);
    strobes.pcLoad   = !rst && xferDone && lastXfer;
    strobes.step     = stepQ;
  end

endmodule

// File: rtl/opStateDatapath.sv
module opStateDatapath
  import opStatePkg::*;
#(
  parameter int          DW       = 32,
  parameter int          PSR_W    = 16,
  parameter int          MOD_W    = 16,
  parameter logic [DW-1:0] SP_RESET = '0,
  parameter logic [DW-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  ctrlStrobe_t      strobes,
  input  logic [DW-1:0]    pcIn,
  input  logic [PSR_W-1:0] psrIn,
  input  logic [MOD_W-1:0] modIn,
  input  logic [DW-1:0]    vecAddr,
  input  logic [DW-1:0]    memRdata,
  output logic [DW-1:0]    memAddr,
  output logic             memWe,
  output logic [DW-1:0]    memWdata,
  output logic [DW-1:0]    sp,
  output logic [DW-1:0]    pcOut,
  output logic [DW-1:0]    linkOut,
  output logic             pcLoaded
);

  localparam int CTX_W = PSR_W + MOD_W;
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] ctxWordD, ctxWordQ, ctxPcQ, ctxVecQ;
  logic [DW-1:0] spQ, pcQ, linkQ;
  logic          loadedQ;

  generate
    if (CTX_W < DW) begin : g_ctxPad
      assign ctxWordD = {{(DW-CTX_W){1'b0}}, psrIn, modIn};
    end else begin : g_ctxFull
      assign ctxWordD = DW'({psrIn, modIn});
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.latchCtx) begin
      ctxWordQ <= ctxWordD;
      ctxPcQ   <= pcIn;
      ctxVecQ  <= vecAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.initRegs) begin
      spQ     <= SP_RESET;
      pcQ     <= RESET_PC;
      linkQ   <= '0;
      loadedQ <= 1'b0;
    end else begin
      if (strobes.spDec)    spQ   <= spQ - ONE;
      if (strobes.linkLoad) linkQ <= memRdata;
      if (strobes.pcLoad)   pcQ   <= memRdata;
      loadedQ <= strobes.pcLoad;
    end
  end

  always_comb begin
    memAddr  = spQ - ONE;
    memWe    = 1'b0;
    memWdata = ctxWordQ;
    unique case (strobes.step)
      XF_PUSH_CTX: begin
        memWe    = 1'b1;
        memWdata = ctxWordQ;
      end
      XF_PUSH_PC: begin
        memWe    = 1'b1;
        memWdata = ctxPcQ;
      end
      XF_READ_LINK: memAddr = ctxVecQ;
      XF_READ_PC:   memAddr = ctxVecQ + ONE;
      default:      memAddr = spQ - ONE;
    endcase
  end

  assign sp       = spQ;
  assign pcOut    = pcQ;
  assign linkOut  = linkQ;
  assign pcLoaded = loadedQ;

endmodule

// File: rtl/opStateTop.sv
module opStateTop
  import opStatePkg::*;
#(
  parameter int            DW       = 32,
  parameter int            PSR_W    = 16,
  parameter int            MOD_W    = 16,
  parameter logic [DW-1:0] SP_RESET = DW'(32'h0000_1000),
  parameter logic [DW-1:0] RESET_PC = DW'(32'h0000_0100)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             excReq,
  input  logic             waitReq,
  input  logic             intReq,
  input  logic [DW-1:0]    pcIn,
  input  logic [PSR_W-1:0] psrIn,
  input  logic [MOD_W-1:0] modIn,
  input  logic [DW-1:0]    vecAddr,
  output logic             memReq,
  output logic             memWe,
  output logic [DW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  input  logic             memReady,
  input  logic [DW-1:0]    memRdata,
  output logic [2:0]       statusCode,
  output logic [DW-1:0]    sp,
  output logic [DW-1:0]    pcOut,
  output logic [DW-1:0]    linkOut,
  output logic             pcLoaded
);

  opState_e    stateQ;
  ctrlStrobe_t strobes;

  opStateCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .excReq   (excReq),
    .waitReq  (waitReq),
    .intReq   (intReq),
    .memReady (memReady),
    .stateQ   (stateQ),
    .memReq   (memReq),
    .strobes  (strobes)
  );

  opStateDatapath #(
    .DW       (DW),
    .PSR_W    (PSR_W),
    .MOD_W    (MOD_W),
    .SP_RESET (SP_RESET),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .pcIn     (pcIn),
    .psrIn    (psrIn),
    .modIn    (modIn),
    .vecAddr  (vecAddr),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memWdata (memWdata),
    .sp       (sp),
    .pcOut    (pcOut),
    .linkOut  (linkOut),
    .pcLoaded (pcLoaded)
  );

  assign statusCode = stateQ;

endmodule

// File: rtl/opStateChecker.sv
module opStateChecker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          excReq,
  input logic          intReq,
  input logic          memReq,
  input logic          memWe,
  input logic [DW-1:0] memAddr,
  input logic [DW-1:0] memWdata,
  input logic          memReady,
  input logic [2:0]    statusCode,
  input logic [DW-1:0] sp,
  input logic          pcLoaded
);

  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= rst;

  always_ff @(posedge clk) begin
    // R2
    if (rstSeen) reset_state_chk: assert (statusCode == 3'b000);
    // R9
    if (rst) reset_no_req_chk: assert (!memReq);
  end

  // R3
  reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (statusCode == 3'b000) |=> (statusCode == 3'b001));

  // R4
  exc_priority_chk: assert property (@(posedge clk) disable iff (rst)
    ((statusCode == 3'b001) && excReq) |=> (statusCode == 3'b010));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((statusCode == 3'b011) && !intReq) |=> (statusCode == 3'b011));

  // R7
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R7
  sp_push_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && memReady && memWe) |=> (sp == $past(sp) - DW'(1)));

  // R8
  load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pcLoaded |-> ((statusCode == 3'b001) && !memReq));

  // R8
  load_single_chk: assert property (@(posedge clk) disable iff (rst)
    pcLoaded |=> !pcLoaded);

  // R9
  req_only_exc_chk: assert property (@(posedge clk) disable iff (rst)
    memReq |-> (statusCode == 3'b010));

endmodule

bind opStateTop opStateChecker #(.DW(DW)) i_opStateChecker (
  .clk        (clk),
  .rst        (rst),
  .excReq     (excReq),
  .intReq     (intReq),
  .memReq     (memReq),
  .memWe      (memWe),
  .memAddr    (memAddr),
  .memWdata   (memWdata),
  .memReady   (memReady),
  .statusCode (statusCode),
  .sp         (sp),
  .pcLoaded   (pcLoaded)
);

// File: tb/test_opStateTop.sv
`timescale 1ns/1ps
module test_opStateTop;

  localparam logic [31:0] SP_RST = 32'h0000_1000;
  localparam logic [31:0] PC_RST = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1, excReq = 1'b0, waitReq = 1'b0, intReq = 1'b0, memReady = 1'b0;
  logic [31:0] pcIn = '0, vecAddr = '0;
  logic [15:0] psrIn = '0, modIn = '0;
  logic        memReq, memWe, pcLoaded;
  logic [31:0] memAddr, memWdata, memRdata, sp, pcOut, linkOut;
  logic [2:0]  statusCode;

  int checks = 0, errors = 0, cyc = 0, readyMode = 0;
  bit started = 0, done = 0;
  string phase = "R2 reset";

  always #10 clk = ~clk;

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return a ^ 32'h5A3C_0F00;
  endfunction
  assign memRdata = memFn(memAddr);

  opStateTop #(.SP_RESET(SP_RST), .RESET_PC(PC_RST)) i_opStateTop (
    .clk(clk), .rst(rst), .excReq(excReq), .waitReq(waitReq), .intReq(intReq),
    .pcIn(pcIn), .psrIn(psrIn), .modIn(modIn), .vecAddr(vecAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata), .statusCode(statusCode),
    .sp(sp), .pcOut(pcOut), .linkOut(linkOut), .pcLoaded(pcLoaded)
  );

  // Free-running context and memory pacing, changed just after each edge.
  always @(posedge clk) begin
    #2;
    cyc++;
    pcIn    = 32'h0000_4000 + cyc * 4;
    psrIn   = 16'h0800 + 16'(cyc);
    modIn   = 16'h0030 + 16'(cyc * 3);
    vecAddr = 32'h0000_0200 + 32'(cyc % 7) * 2;
    case (readyMode)
      0: memReady = 1'b1;
      1: memReady = (cyc % 3 == 0);
      default: memReady = (cyc % 5 != 0);
    endcase
  end

  // Behavioural reference: integer state, step counter and saved context.
  int          mState = 0, mStep = 0;
  logic [31:0] mSp, mPc, mLink, mCtxPc, mVec, mCtxWord;
  bit          mLoad;

  function automatic logic [31:0] expAddr();
    case (mStep)
      0, 1:    return mSp - 1;
      2:       return mVec;
      default: return mVec + 1;
    endcase
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      mState = 0; mStep = 0; mSp = SP_RST; mPc = PC_RST; mLink = 0; mLoad = 0;
    end else begin
      mLoad = 0;
      case (mState)
        0: mState = 1;
        1: begin
          if (excReq) begin
            mCtxWord = {psrIn, modIn}; mCtxPc = pcIn; mVec = vecAddr;
            mState = 2; mStep = 0;
          end else if (waitReq) mState = 3;
        end
        3: begin
          if (intReq) begin
            mCtxWord = {psrIn, modIn}; mCtxPc = pcIn; mVec = vecAddr;
            mState = 2; mStep = 0;
          end
        end
        default: begin
          if (memReady) begin
            case (mStep)
              0, 1: mSp = mSp - 1;
              2:    mLink = memFn(mVec);
              default: begin
                mPc = memFn(mVec + 1); mState = 1; mLoad = 1;
              end
            endcase
            mStep = (mStep + 1) % 4;
          end
        end
      endcase
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s: actual %h expected %h", tag, phase, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      bit expReq;
      chk("R1", "statusCode", {29'b0, statusCode}, 32'(mState));
      expReq = (mState == 2) && !rst;
      chk(expReq ? "R7" : "R9", "memReq", {31'b0, memReq}, {31'b0, expReq});
      if (expReq) begin
        chk("R6", "memAddr", memAddr, expAddr());
        chk("R6", "memWe", {31'b0, memWe}, {31'b0, mStep < 2});
        if (mStep < 2) chk("R6", "memWdata", memWdata, (mStep == 0) ? mCtxWord : mCtxPc);
      end
      chk("R7", "sp", sp, mSp);
      chk("R8", "pcOut", pcOut, mPc);
      chk("R8", "linkOut", linkOut, mLink);
      chk("R8", "pcLoaded", {31'b0, pcLoaded}, {31'b0, mLoad});
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog [%s]: actual timeout expected completion", phase);
    finishRun();
  end

  initial begin
    phase = "R2 reset"; rst = 1; tick(3);
    rst = 0; phase = "R3 leave reset"; tick(3);
    phase = "R4 intReq ignored while running"; intReq = 1; tick(2); intReq = 0;
    phase = "R6 entry with fast memory"; readyMode = 0;
    excReq = 1; tick(); excReq = 0; tick(8);
    phase = "R10 strobes ignored during service"; readyMode = 1;
    excReq = 1; tick(); excReq = 0; tick();
    waitReq = 1; intReq = 1; excReq = 1; tick(3);
    waitReq = 0; intReq = 0; excReq = 0; tick(15);
    phase = "R4 exception beats wait"; readyMode = 2;
    excReq = 1; waitReq = 1; tick(); excReq = 0; waitReq = 0; tick(10);
    phase = "R5 waiting"; waitReq = 1; tick(); waitReq = 0; tick(3);
    excReq = 1; waitReq = 1; tick(2); excReq = 0; waitReq = 0; tick(2);
    intReq = 1; tick(); intReq = 0; tick(12);
    phase = "R9 reset abandons transfer"; readyMode = 1;
    excReq = 1; tick(); excReq = 0; tick(2);
    rst = 1; tick(2); rst = 0; tick(3);
    phase = "R2 reset from waiting"; waitReq = 1; tick(); waitReq = 0; tick(2);
    rst = 1; tick(); rst = 0; tick(4);
    phase = "R8 back-to-back exceptions"; readyMode = 0;
    excReq = 1; tick(6); excReq = 0; tick(10);
    finishRun();
  end

endmodule